// File: doc/BRIEF.md
# Ternary Operand Stack Controller

This block is the operand stack of a small stack-oriented processor whose data words are balanced-ternary trytes of six trits. Each trit travels on two binary wires. The stack holds at most nine words, which is the range of a two-trit pointer. Each cycle it accepts one command: push, pop, nip, duplicate, flip or rotate. The two uppermost words are always visible on read ports, together with the current depth and the full and empty flags.

A push also carries a one-trit destination code. The code decides whether the incoming result goes onto the stack, goes only to a one-cycle output port, or goes to both. A command that would overflow or underflow the stack leaves the stack as it was and raises a one-cycle error pulse. Instruction fetch, decode and arithmetic belong to the surrounding processor.

Commands arrive on a valid/ready handshake. A command is taken on a rising edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low during reset and for the first edge after it, and high on every cycle after that, so the stack never applies back-pressure once it is running. The output port has no ready signal: the consumer must accept `out_data` in the single cycle in which `out_valid` is high.

Top module: `tstk_ctrl`

## Requirements
- R1: While reset is active, and just after it is released, depth is 0, `empty` is 1, `full` is 0, `err` and `out_valid` are 0, and both read ports show zero. `cmd_ready` is 0 until the first rising edge after reset is released, and 1 from then on.
- R2: Each trit is coded as 00 = o (zero), 01 = + and 10 = −. A push (op code 1) whose destination trit is o writes `cmd_data` to the top of the stack and increases depth by one.
- R3: A pop (op code 2) on a non-empty stack removes the top word and decreases depth by one. The former second word becomes the top.
- R4: A nip (op code 3) with at least two words removes the second word, keeps the top word, and decreases depth by one.
- R5: A duplicate (op code 4) with at least one word and at least one free slot pushes a copy of the top word.
- R6: A flip (op code 5) with at least two words exchanges the top and second words. Depth does not change.
- R7: A rotate (op code 6) with at least three words moves the third word to the top. The former top becomes the second word and the former second becomes the third. Depth does not change.
- R8: A push whose destination trit is − leaves the stack unchanged. It raises `out_valid` for exactly one cycle after the edge, with `out_data` equal to the pushed word.
- R9: A push whose destination trit is + does both: it pushes the word and pulses `out_valid` with that word.
- R10: A push with destination o or +, or a duplicate, while depth is 9 leaves the stack unchanged and raises `err` for one cycle. For destination +, no output pulse is produced in this case.
- R11: A pop on 0 words, a nip or flip on fewer than 2 words, a rotate on fewer than 3 words, or a duplicate on an empty stack leaves the stack unchanged and raises `err` for one cycle.
- R12: `full` is 1 exactly when depth is 9, and `empty` is 1 exactly when depth is 0. A read port whose entry does not exist shows zero.
- R13: When `cmd_valid` is low, or the op code is 0 or 7, the stack, `err` and `out_valid` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; empties the stack |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The stack accepts commands |
| cmd_op | input | 3 | Op code: 1 push, 2 pop, 3 nip, 4 dup, 5 flip, 6 rotate, 0/7 none |
| cmd_dest | input | 2 | Destination trit for push: − output only, o stack only, + both |
| cmd_data | input | 12 | Word to push, six trits of two bits each |
| top_data | output | 12 | Top word, or zero when the stack is empty |
| second_data | output | 12 | Second word, or zero when fewer than two words are held |
| depth | output | 4 | Number of words held, 0 to 9 |
| full | output | 1 | Depth is 9 |
| empty | output | 1 | Depth is 0 |
| err | output | 1 | One-cycle pulse: the last command was refused |
| out_valid | output | 1 | One-cycle pulse: `out_data` carries a routed result |
| out_data | output | 12 | Routed result word |

## Verification
The assertions assume that a push never carries the unused destination code 11. They also assume that depth comparisons start from a stack emptied by reset, so no property looks back past reset. Data trits with the code 11 are outside the contract, and the assertions do not depend on word contents except through pushes, swaps and rotations. The stimulus builds every word from the three legal trit codes. It draws destinations only from −, o and +, and drives op codes 0 and 7 only as no-ops. Runs of pushes and pops are biased so that the stack repeatedly reaches both empty and full, where the refusal rules apply.

// File: rtl/tstk_pkg.sv
package tstk_pkg;

  // Command codes accepted on cmd_op
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_NIP  = 3'd3,
    OP_DUP  = 3'd4,
    OP_FLIP = 3'd5,
    OP_ROT  = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  // Two-wire trit codes
  localparam logic [1:0] TRIT_ZERO = 2'b00;
  localparam logic [1:0] TRIT_POS  = 2'b01;
  localparam logic [1:0] TRIT_NEG  = 2'b10;

endpackage

// File: rtl/tstk_guard.sv
module tstk_guard
  import tstk_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int CW    = 4
) (
  input  logic          fire_i,
  input  op_e           op_i,
  input  logic [1:0]    dest_i,
  input  logic [CW-1:0] depth_i,
  output logic          do_stack_o,
  output logic          do_out_o,
  output logic          refuse_o
);

  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic has1, has2, has3, room;

  assign has1 = depth_i >= CW'(1);
  assign has2 = depth_i >= CW'(2);
  assign has3 = depth_i >= CW'(3);
  assign room = depth_i <  LIMIT;

  always_comb begin
    do_stack_o = 1'b0;
    do_out_o   = 1'b0;
    refuse_o   = 1'b0;
    if (fire_i) begin
      unique case (op_i)
        OP_PUSH: begin
          if (dest_i == TRIT_NEG) begin
            do_out_o = 1'b1;
          end else if (!room) begin
            refuse_o = 1'b1;
          end else begin
            do_stack_o = 1'b1;
            do_out_o   = (dest_i == TRIT_POS);
          end
        end
        OP_POP:  begin do_stack_o = has1;         refuse_o = !has1; end
        OP_NIP:  begin do_stack_o = has2;         refuse_o = !has2; end
        OP_FLIP: begin do_stack_o = has2;         refuse_o = !has2; end
        OP_ROT:  begin do_stack_o = has3;         refuse_o = !has3; end
        OP_DUP:  begin do_stack_o = has1 && room; refuse_o = !(has1 && room); end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tstk_regs.sv
module tstk_regs
  import tstk_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int TW    = 12,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  op_e           op_i,
  input  logic [TW-1:0] wdata_i,
  input  logic [CW-1:0] depth_i,
  output logic [TW-1:0] top_o,
  output logic [TW-1:0] sec_o
);

  logic [TW-1:0] mem [DEPTH];
  logic [TW-1:0] w0, w1, w2;
  logic [CW-1:0] i0, i1, i2;

  assign i0 = depth_i - CW'(1);
  assign i1 = depth_i - CW'(2);
  assign i2 = depth_i - CW'(3);

  // Select the three uppermost words
  always_comb begin
    w0 = '0;
    w1 = '0;
    w2 = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (CW'(k) == i0) w0 = mem[k];
      if (CW'(k) == i1) w1 = mem[k];
      if (CW'(k) == i2) w2 = mem[k];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [CW-1:0] IDX = CW'(g);
    logic [TW-1:0] q, nxt;

    always_comb begin
      nxt = q;
      if (en_i) begin
        unique case (op_i)
          OP_PUSH: if (IDX == depth_i) nxt = wdata_i;
          OP_DUP:  if (IDX == depth_i) nxt = w0;
          OP_NIP:  if (IDX == i1) nxt = w0;
          OP_FLIP: begin
            if (IDX == i0) nxt = w1;
            if (IDX == i1) nxt = w0;
          end
          OP_ROT: begin
            if (IDX == i0) nxt = w2;
            if (IDX == i1) nxt = w0;
            if (IDX == i2) nxt = w1;
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end

    assign mem[g] = q;
  end

  assign top_o = (depth_i >= CW'(1)) ? w0 : '0;
  assign sec_o = (depth_i >= CW'(2)) ? w1 : '0;

  assert_flip_swaps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && op_i == OP_FLIP |=> top_o == $past(sec_o) && sec_o == $past(top_o));

  assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && op_i == OP_PUSH |=> top_o == $past(wdata_i) && sec_o == $past(top_o));

  assert_rot_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && op_i == OP_ROT |=> sec_o == $past(top_o));

endmodule

// File: rtl/tstk_ctrl.sv
module tstk_ctrl
  import tstk_pkg::*;
#(
  parameter int TRITS = 6,
  parameter int DEPTH = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic [2:0]                     cmd_op,
  input  logic [1:0]                     cmd_dest,
  input  logic [2*TRITS-1:0]             cmd_data,
  output logic [2*TRITS-1:0]             top_data,
  output logic [2*TRITS-1:0]             second_data,
  output logic [$clog2(DEPTH+1)-1:0]     depth,
  output logic                           full,
  output logic                           empty,
  output logic                           err,
  output logic                           out_valid,
  output logic [2*TRITS-1:0]             out_data
);

  localparam int TW = 2 * TRITS;
  localparam int CW = $clog2(DEPTH + 1);

  op_e  op;
  logic fire, do_stack, do_out, refuse;

  assign op   = op_e'(cmd_op);
  assign fire = cmd_valid && cmd_ready;

  tstk_guard #(.DEPTH(DEPTH), .CW(CW)) guard_i (
    .fire_i     (fire),
    .op_i       (op),
    .dest_i     (cmd_dest),
    .depth_i    (depth),
    .do_stack_o (do_stack),
    .do_out_o   (do_out),
    .refuse_o   (refuse)
  );

  tstk_regs #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (do_stack),
    .op_i    (op),
    .wdata_i (cmd_data),
    .depth_i (depth),
    .top_o   (top_data),
    .sec_o   (second_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth     <= '0;
      cmd_ready <= 1'b0;
      err       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      cmd_ready <= 1'b1;
      err       <= refuse;
      out_valid <= do_out;
      if (do_out) out_data <= cmd_data;
      if (do_stack) begin
        unique case (op)
          OP_PUSH, OP_DUP: depth <= depth + CW'(1);
          OP_POP, OP_NIP:  depth <= depth - CW'(1);
          default: ;
        endcase
      end
    end
  end

  assign full  = (depth == CW'(DEPTH));
  assign empty = (depth == '0);

  assert_depth_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

  assert_refuse_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(depth) && !out_valid);

  assert_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_POP && empty |=> err);

  assert_out_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_PUSH && cmd_dest == TRIT_NEG |=> out_valid && $stable(depth)
      && out_data == $past(cmd_data));

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(depth) && !err && !out_valid);

  assert_dest_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_PUSH |-> cmd_dest != 2'b11);

endmodule

// File: tb/tstk_ctrl_tb.sv
module tstk_ctrl_tb_top;

  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [2:0]    cmd_op;
  logic [1:0]    cmd_dest;
  logic [TW-1:0] cmd_data;
  logic [TW-1:0] top_data, second_data, out_data;
  logic [3:0]    depth;
  logic          full, empty, err, out_valid;

  always #2 clk = ~clk;

  tstk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dest(cmd_dest), .cmd_data(cmd_data),
    .top_data(top_data), .second_data(second_data), .depth(depth),
    .full(full), .empty(empty), .err(err), .out_valid(out_valid),
    .out_data(out_data)
  );

  int vectors = 0;
  int misses  = 0;

  logic [TW-1:0] q[$];
  logic          e_rdy, e_err, e_ov;
  logic [TW-1:0] e_od;

  task automatic chk(string req, string what, logic [TW-1:0] act, logic [TW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    int n = q.size();
    chk(req, "top", top_data, n >= 1 ? q[n-1] : '0);
    chk(req, "second", second_data, n >= 2 ? q[n-2] : '0);
    chk(req, "depth", TW'(depth), TW'(n));
    chk("R12", "full", TW'(full), TW'(n == 9));
    chk("R12", "empty", TW'(empty), TW'(n == 0));
    chk(req, "err", TW'(err), TW'(e_err));
    chk(req, "out_valid", TW'(out_valid), TW'(e_ov));
    if (e_ov) chk(req, "out_data", out_data, e_od);
    chk("R1", "cmd_ready", TW'(cmd_ready), TW'(e_rdy));
  endtask

  function automatic logic [TW-1:0] rnd_word();
    logic [TW-1:0] w;
    for (int t = 0; t < 6; t++) begin
      int r = $urandom_range(0, 2);
      w[2*t +: 2] = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b10;
    end
    return w;
  endfunction

  function automatic void model(logic v, logic [2:0] op, logic [1:0] dst, logic [TW-1:0] d);
    int n = q.size();
    logic [TW-1:0] a, b, c;
    e_err = 1'b0;
    e_ov  = 1'b0;
    if (v && e_rdy) begin
      case (op)
        3'd1: begin
          if (dst == 2'b10) begin e_ov = 1'b1; e_od = d; end
          else if (n == 9) e_err = 1'b1;
          else begin
            q.push_back(d);
            if (dst == 2'b01) begin e_ov = 1'b1; e_od = d; end
          end
        end
        3'd2: if (n >= 1) void'(q.pop_back()); else e_err = 1'b1;
        3'd3: if (n >= 2) begin a = q.pop_back(); void'(q.pop_back()); q.push_back(a); end
              else e_err = 1'b1;
        3'd4: if (n >= 1 && n < 9) q.push_back(q[n-1]); else e_err = 1'b1;
        3'd5: if (n >= 2) begin a = q[n-1]; q[n-1] = q[n-2]; q[n-2] = a; end
              else e_err = 1'b1;
        3'd6: if (n >= 3) begin
                a = q[n-3]; b = q[n-2]; c = q[n-1];
                q[n-1] = a; q[n-2] = c; q[n-3] = b;
              end else e_err = 1'b1;
        default: ;
      endcase
    end
    e_rdy = 1'b1;
  endfunction

  // Called at a negedge: check outputs, drive the command, advance the model
  task automatic step(string req, logic v, logic [2:0] op, logic [1:0] dst, logic [TW-1:0] d);
    compare(req);
    cmd_valid = v; cmd_op = op; cmd_dest = dst; cmd_data = d;
    @(posedge clk);
    model(v, op, dst, d);
    @(negedge clk);
  endtask

  task automatic push(string req, logic [1:0] dst, logic [TW-1:0] d);
    step(req, 1'b1, 3'd1, dst, d);
  endtask

  task automatic opx(string req, logic [2:0] op);
    step(req, 1'b1, op, 2'b00, rnd_word());
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    misses++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_dest = '0; cmd_data = '0;
    e_rdy = 1'b0; e_err = 1'b0; e_ov = 1'b0; e_od = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step("R1", 1'b1, 3'd1, 2'b00, 12'h155); // ignored: not yet ready
    // Underflow on empty stack
    opx("R11", 3'd2); opx("R11", 3'd4); opx("R11", 3'd3);
    push("R2", 2'b00, 12'h001);
    opx("R11", 3'd5); opx("R11", 3'd6);
    opx("R5", 3'd4);
    push("R9", 2'b01, 12'h2a6);
    push("R2", 2'b00, 12'h419);
    opx("R7", 3'd6);
    opx("R6", 3'd5);
    opx("R4", 3'd3);
    push("R8", 2'b10, 12'h999);
    opx("R3", 3'd2);
    step("R13", 1'b0, 3'd2, 2'b00, '0);
    step("R13", 1'b1, 3'd0, 2'b00, '0);
    step("R13", 1'b1, 3'd7, 2'b00, '0);
    // Fill to the limit
    repeat (9) push("R2", 2'b00, rnd_word());
    push("R10", 2'b00, 12'h111);
    push("R10", 2'b01, 12'h222);
    opx("R10", 3'd4);
    push("R8", 2'b10, 12'h844);
    opx("R7", 3'd6); opx("R6", 3'd5);
    repeat (10) opx("R3", 3'd2);
    // Random traffic with drifting bias
    for (int i = 0; i < 4000; i++) begin
      int bias = (i / 200) % 2;
      int r = $urandom_range(0, 19);
      logic [2:0] op;
      logic [1:0] dst;
      int dr = $urandom_range(0, 2);
      if (r < (bias ? 8 : 3)) op = 3'd1;
      else if (r < 11) op = 3'd2;
      else op = 3'($urandom_range(0, 7));
      dst = (dr == 0) ? 2'b10 : (dr == 1) ? 2'b00 : 2'b01;
      step("R2", $urandom_range(0, 9) != 0, op, dst, rnd_word());
    end
    compare("R12");
    finish_run();
  end

endmodule